// File: doc/BRIEF.md
# Single-to-Dual Pixel Splitter

This block takes a stream of one 24-bit pixel per clock, with horizontal sync, vertical sync and data enable, and regroups it into pixel pairs. Each pair is 48 bits wide and is presented once every two input clocks, so a downstream serializer or link can run at half the input pixel rate. For example, a 170 MHz single-pixel source becomes an 85 MHz dual-pixel stream. The pairing runs in the input clock domain, and a one-cycle valid strobe marks each completed pair. Balanced and unbalanced link coding both sit downstream and do not affect the splitter.

Pairing does not free-run. Each low-to-high edge of data enable restarts it, so the first active pixel of every line always lands in the first (odd) half of the pair. Blanking periods are expected to have an even number of clocks. If a blanking period has an odd length, the block still realigns on the next active edge and sets a sticky error flag. If a line has an odd number of active pixels, its last pair is completed with a zero even pixel. The syncs and data enable in a pair always come from the odd pixel's cycle.

Top module: `pix_pair_splitter`

## Requirements
- R1: While reset is held, out_valid, out_pair, out_hsync, out_vsync, out_de and odd_blank_err are all zero.
- R2: The first pixel sampled with in_de high after a cycle with in_de low becomes the odd pixel, in out_pair[23:0]. The following pixel becomes the even pixel, in out_pair[47:24]. The pair appears, with out_valid high, just after the clock edge that samples the even pixel.
- R3: out_valid stays low after the edge that samples an odd pixel. It is high for exactly one cycle per completed pair.
- R4: out_hsync, out_vsync and out_de of a pair equal the in_hsync, in_vsync and in_de sampled with the odd pixel.
- R5: Blanking cycles (in_de low) are paired in the same way, so the syncs keep moving at half rate during blanking.
- R6: When every blanking period has an even length, odd_blank_err stays low and each line's first active pixel sits in the odd half.
- R7: If in_de rises while an odd pixel is held (an odd-length blanking period), the held pixel is emitted with zero in out_pair[47:24], the new pixel becomes the odd pixel, and odd_blank_err is set. The flag stays high until reset.
- R8: If in_de falls while an active odd pixel is held, that pixel is emitted with zero in out_pair[47:24] and out_de high. The pixel sampled in the falling cycle becomes the next odd pixel.
- R9: Between valid strobes, out_pair and the output controls keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_pix | input | 24 | Incoming pixel |
| in_hsync | input | 1 | Incoming horizontal sync |
| in_vsync | input | 1 | Incoming vertical sync |
| in_de | input | 1 | Incoming data enable, high on active pixels |
| out_pair | output | 48 | Pixel pair: odd in [23:0], even in [47:24] |
| out_hsync | output | 1 | Horizontal sync of the pair's odd pixel |
| out_vsync | output | 1 | Vertical sync of the pair's odd pixel |
| out_de | output | 1 | Data enable of the pair's odd pixel |
| out_valid | output | 1 | One-cycle strobe per completed pair |
| odd_blank_err | output | 1 | Sticky flag: a blanking period of odd length was seen |

## Verification
The properties assume that in_de is low throughout reset and during the synchronizer release, so the first edge of data enable after reset is a clean rising edge. The stimulus drives every input half a clock away from the sampling edge and holds in_de low during reset. Each line starts with a blanking run whose length is chosen so that the pairing phase is known before the first active pixel. Odd-length blanking and odd-length active runs appear only in the scenarios that target the padding and error behaviour, so every other expected pair has a fixed cycle position.

// File: rtl/splt_pkg.sv
package splt_pkg;
  typedef enum logic {
    PH_ODD  = 1'b0,
    PH_EVEN = 1'b1
  } phase_e;

  typedef struct packed {
    logic hs;
    logic vs;
    logic de;
  } ctrl_t;
endpackage

// File: rtl/splt_phase_ctl.sv
module splt_phase_ctl
  import splt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_de,
  input  logic held_de,
  output logic take_odd,
  output logic emit,
  output logic pad_even,
  output logic ph_even,
  output logic err_flag
);
  phase_e ph_q, ph_d;
  logic   de_prev_q;
  logic   err_q, err_d;
  logic   de_rise, de_drop;

  assign de_rise = in_de & ~de_prev_q;
  assign de_drop = held_de & ~in_de;

  always_comb begin
    ph_d     = ph_q;
    err_d    = err_q;
    take_odd = 1'b0;
    emit     = 1'b0;
    pad_even = 1'b0;
    if (ph_q == PH_ODD) begin
      take_odd = 1'b1;
      ph_d     = PH_EVEN;
    end else if (de_rise || de_drop) begin
      emit     = 1'b1;
      pad_even = 1'b1;
      take_odd = 1'b1;
      ph_d     = PH_EVEN;
      if (de_rise) err_d = 1'b1;
    end else begin
      emit = 1'b1;
      ph_d = PH_ODD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q      <= PH_ODD;
      de_prev_q <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      ph_q      <= ph_d;
      de_prev_q <= in_de;
      err_q     <= err_d;
    end
  end

  assign ph_even  = (ph_q == PH_EVEN);
  assign err_flag = err_q;
endmodule

// File: rtl/splt_hold.sv
module splt_hold
  import splt_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PIX_W-1:0] in_pix,
  input  ctrl_t            in_ctrl,
  output logic [PIX_W-1:0] held_pix,
  output ctrl_t            held_ctrl
);
  logic [PIX_W-1:0] pix_q, pix_d;
  ctrl_t            ctl_q, ctl_d;

  always_comb begin
    pix_d = pix_q;
    ctl_d = ctl_q;
    if (load) begin
      pix_d = in_pix;
      ctl_d = in_ctrl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_q <= '0;
      ctl_q <= '0;
    end else begin
      pix_q <= pix_d;
      ctl_q <= ctl_d;
    end
  end

  assign held_pix  = pix_q;
  assign held_ctrl = ctl_q;
endmodule

// File: rtl/splt_out.sv
module splt_out
  import splt_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               emit,
  input  logic               pad,
  input  logic [PIX_W-1:0]   odd_pix,
  input  ctrl_t              odd_ctrl,
  input  logic [PIX_W-1:0]   even_pix,
  output logic [2*PIX_W-1:0] pair,
  output ctrl_t              pair_ctrl,
  output logic               valid
);
  localparam int PAIR_W = 2 * PIX_W;

  logic [PAIR_W-1:0] pair_q, pair_d;
  ctrl_t             ctl_q, ctl_d;
  logic              vld_q;
  logic [PIX_W-1:0]  even_sel;

  assign even_sel = pad ? '0 : even_pix;

  always_comb begin
    pair_d = pair_q;
    ctl_d  = ctl_q;
    if (emit) begin
      pair_d = {even_sel, odd_pix};
      ctl_d  = odd_ctrl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair_q <= '0;
      ctl_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      pair_q <= pair_d;
      ctl_q  <= ctl_d;
      vld_q  <= emit;
    end
  end

  assign pair      = pair_q;
  assign pair_ctrl = ctl_q;
  assign valid     = vld_q;
endmodule

// File: rtl/pix_pair_splitter.sv
module pix_pair_splitter
  import splt_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PIX_W-1:0]   in_pix,
  input  logic               in_hsync,
  input  logic               in_vsync,
  input  logic               in_de,
  output logic [2*PIX_W-1:0] out_pair,
  output logic               out_hsync,
  output logic               out_vsync,
  output logic               out_de,
  output logic               out_valid,
  output logic               odd_blank_err
);
  logic rst_meta, rst_core_n;

  // reset asserts at once, releases after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_core_n <= rst_meta;
    end
  end

  ctrl_t            in_ctrl, held_ctrl, pair_ctrl;
  logic [PIX_W-1:0] held_pix;
  logic             take_odd, emit, pad_even, ph_even, held_de;

  assign in_ctrl = '{hs: in_hsync, vs: in_vsync, de: in_de};
  assign held_de = held_ctrl.de;

  splt_phase_ctl u_ctl (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .in_de    (in_de),
    .held_de  (held_de),
    .take_odd (take_odd),
    .emit     (emit),
    .pad_even (pad_even),
    .ph_even  (ph_even),
    .err_flag (odd_blank_err)
  );

  splt_hold #(.PIX_W(PIX_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .load      (take_odd),
    .in_pix    (in_pix),
    .in_ctrl   (in_ctrl),
    .held_pix  (held_pix),
    .held_ctrl (held_ctrl)
  );

  splt_out #(.PIX_W(PIX_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .emit      (emit),
    .pad       (pad_even),
    .odd_pix   (held_pix),
    .odd_ctrl  (held_ctrl),
    .even_pix  (in_pix),
    .pair      (out_pair),
    .pair_ctrl (pair_ctrl),
    .valid     (out_valid)
  );

  assign out_hsync = pair_ctrl.hs;
  assign out_vsync = pair_ctrl.vs;
  assign out_de    = pair_ctrl.de;
endmodule

// File: rtl/splt_chk.sv
module splt_chk #(
  parameter int PIX_W = 24
) (
  input logic               clk,
  input logic               rst_core_n,
  input logic               in_de,
  input logic               ph_even,
  input logic               held_de,
  input logic               out_valid,
  input logic [2*PIX_W-1:0] out_pair,
  input logic               odd_blank_err
);
  localparam int PAIR_W = 2 * PIX_W;

  a_r2_rise_holds_odd: assert property (@(posedge clk) disable iff (!rst_core_n)
    (in_de && !$past(in_de)) |=> ph_even);

  a_r3_no_strobe_on_odd: assert property (@(posedge clk) disable iff (!rst_core_n)
    !ph_even |=> !out_valid);

  a_r7_err_on_odd_blank: assert property (@(posedge clk) disable iff (!rst_core_n)
    (ph_even && in_de && !$past(in_de)) |=> odd_blank_err);

  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_core_n)
    odd_blank_err |=> odd_blank_err);

  a_r8_pad_zero: assert property (@(posedge clk) disable iff (!rst_core_n)
    (ph_even && held_de && !in_de) |=> (out_valid && out_pair[PAIR_W-1:PIX_W] == '0));

  a_r9_hold_between: assert property (@(posedge clk) disable iff (!rst_core_n)
    !out_valid |-> $stable(out_pair));
endmodule

bind pix_pair_splitter splt_chk #(.PIX_W(PIX_W)) u_chk (
  .clk           (clk),
  .rst_core_n    (rst_core_n),
  .in_de         (in_de),
  .ph_even       (ph_even),
  .held_de       (held_de),
  .out_valid     (out_valid),
  .out_pair      (out_pair),
  .odd_blank_err (odd_blank_err)
);

// File: tb/tb_pix_pair_splitter.sv
`timescale 1ns/1ps
module tb_pix_pair_splitter;
  localparam int PIX_W = 24;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic               rst_n;
  logic [PIX_W-1:0]   in_pix;
  logic               in_hsync, in_vsync, in_de;
  logic [2*PIX_W-1:0] out_pair;
  logic               out_hsync, out_vsync, out_de, out_valid, odd_blank_err;

  int n_chk  = 0;
  int n_fail = 0;

  pix_pair_splitter #(.PIX_W(PIX_W)) dut (
    .clk(clk), .rst_n(rst_n), .in_pix(in_pix), .in_hsync(in_hsync),
    .in_vsync(in_vsync), .in_de(in_de), .out_pair(out_pair),
    .out_hsync(out_hsync), .out_vsync(out_vsync), .out_de(out_de),
    .out_valid(out_valid), .odd_blank_err(odd_blank_err)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one input cycle at a falling edge, return after the next falling edge
  task automatic step(logic [PIX_W-1:0] p, logic hs, logic vs, logic de);
    in_pix = p; in_hsync = hs; in_vsync = vs; in_de = de;
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    in_pix = '0; in_hsync = 1'b0; in_vsync = 1'b0; in_de = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", 64'(out_valid), 64'd0);
    chk("R1 pair in reset", 64'(out_pair), 64'd0);
    chk("R1 ctrl in reset", 64'({out_hsync, out_vsync, out_de}), 64'd0);
    chk("R1 err in reset", 64'(odd_blank_err), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_line_basic;
    step(24'h0000B1, 1'b1, 1'b0, 1'b0);
    chk("R3 no strobe on odd blank", 64'(out_valid), 64'd0);
    step(24'h0000B2, 1'b0, 1'b0, 1'b0);
    chk("R5 blank pair valid", 64'(out_valid), 64'd1);
    chk("R5 blank pair data", 64'(out_pair), 64'h0000B2_0000B1);
    chk("R4 hsync from odd", 64'({out_hsync, out_de}), 64'b10);
    step(24'h111111, 1'b0, 1'b1, 1'b1);
    chk("R3 no strobe on first active", 64'(out_valid), 64'd0);
    step(24'h222222, 1'b0, 1'b0, 1'b1);
    chk("R2 first pair order", 64'(out_pair), 64'h222222_111111);
    chk("R2 first pair strobe", 64'(out_valid), 64'd1);
    chk("R4 vsync and de from odd", 64'({out_vsync, out_de}), 64'b11);
    step(24'h333333, 1'b0, 1'b0, 1'b1);
    chk("R9 pair held", 64'(out_pair), 64'h222222_111111);
    chk("R3 strobe one cycle", 64'(out_valid), 64'd0);
    step(24'h444444, 1'b0, 1'b0, 1'b1);
    chk("R2 second pair", 64'(out_pair), 64'h444444_333333);
    step(24'h0000C1, 1'b1, 1'b0, 1'b0);
    step(24'h0000C2, 1'b0, 1'b0, 1'b0);
    chk("R5 blank pair after line", 64'(out_pair), 64'h0000C2_0000C1);
    step(24'h555555, 1'b0, 1'b0, 1'b1);
    step(24'h666666, 1'b0, 1'b0, 1'b1);
    chk("R6 next line aligned", 64'(out_pair), 64'h666666_555555);
    chk("R6 no error on even blank", 64'(odd_blank_err), 64'd0);
  endtask

  task automatic t_odd_active;
    step(24'h0000D1, 1'b0, 1'b0, 1'b0);
    step(24'h0000D2, 1'b0, 1'b0, 1'b0);
    step(24'hA1A1A1, 1'b0, 1'b0, 1'b1);
    step(24'hA2A2A2, 1'b0, 1'b0, 1'b1);
    step(24'hA3A3A3, 1'b0, 1'b0, 1'b1);
    step(24'h0000E1, 1'b1, 1'b0, 1'b0);
    chk("R8 pad strobe", 64'(out_valid), 64'd1);
    chk("R8 pad pair", 64'(out_pair), 64'h000000_A3A3A3);
    chk("R8 pad de", 64'(out_de), 64'd1);
    step(24'h0000E2, 1'b0, 1'b0, 1'b0);
    chk("R8 drop pixel is odd", 64'(out_pair), 64'h0000E2_0000E1);
    chk("R8 drop pair ctrl", 64'({out_hsync, out_de, out_valid}), 64'b101);
    step(24'h0000E3, 1'b0, 1'b0, 1'b0);
    step(24'h0000E4, 1'b0, 1'b0, 1'b0);
    step(24'hA4A4A4, 1'b0, 1'b0, 1'b1);
    step(24'hA5A5A5, 1'b0, 1'b0, 1'b1);
    chk("R6 aligned after padded line", 64'(out_pair), 64'hA5A5A5_A4A4A4);
    chk("R6 no error after padded line", 64'(odd_blank_err), 64'd0);
  endtask

  task automatic t_odd_blank;
    step(24'h0000F1, 1'b0, 1'b0, 1'b0);
    step(24'h0000F2, 1'b0, 1'b0, 1'b0);
    step(24'h0000F3, 1'b0, 1'b1, 1'b0);
    step(24'hD1D1D1, 1'b0, 1'b0, 1'b1);
    chk("R7 held blank emitted", 64'(out_pair), 64'h000000_0000F3);
    chk("R7 held blank ctrl", 64'({out_vsync, out_de, out_valid}), 64'b101);
    chk("R7 error set", 64'(odd_blank_err), 64'd1);
    step(24'hD2D2D2, 1'b0, 1'b0, 1'b1);
    chk("R7 realigned pair", 64'(out_pair), 64'hD2D2D2_D1D1D1);
    step(24'h0000F4, 1'b0, 1'b0, 1'b0);
    step(24'h0000F5, 1'b0, 1'b0, 1'b0);
    chk("R7 error sticky", 64'(odd_blank_err), 64'd1);
  endtask

  initial begin
    t_reset();
    t_line_basic();
    t_odd_active();
    t_odd_blank();
    t_reset();
    chk("R1 error cleared by reset", 64'(odd_blank_err), 64'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule